// File: doc/BRIEF.md
# Flash Completion Poller

This block runs on the host side of a parallel flash part. Once the host has written the last bus cycle of a program or erase command, it waits for the part to finish. It pulses `start_i` together with the operation kind, the target address and, for a program, the byte being written. The block then issues read cycles over a simple request/acknowledge bus and watches the top status bit of each returned byte.

While the part is busy, that bit reads as the inverse of its final value. For a program, completion is seen when the polled bit equals the same bit of the byte being written. For an erase, completion is seen when the polled bit reads 1. The polled bit can flip before the lower bits have settled, so the block always makes one further read and judges the result on that byte alone.

A cycle-count limit ends a part that never completes. An optional device-error input, sampled with every returned read, ends polling early. Either way the block reports a one-cycle done strobe, a success flag, a timeout flag and the last byte read.

Top module: `flash_status_poller`

## Requirements
- R1: After reset `done_o`, `bus_req_o`, `ok_o` and `timeout_o` are all 0.
- R2: A start is taken only while idle. No read is requested in the cycle that carries `start_i`. From the next cycle, `bus_req_o` is 1 and `bus_addr_o` equals the `addr_i` captured with the start, for every read of that operation.
- R3: For a program (`op_erase_i`=0), a read counts as the completion hit when its bit 7 equals bit 7 of the captured data byte.
- R4: For an erase (`op_erase_i`=1), a read counts as the completion hit when its bit 7 is 1.
- R5: After the hit, exactly one more read is made before done. `result_o` is that confirming byte, so a hit on the n-th read gives n+1 reads in total.
- R6: A program succeeds (`ok_o`=1) only when the confirming byte equals the whole expected byte. An erase succeeds only when bit 7 of the confirming byte is 1.
- R7: If no hit is seen before `tmo_limit_i` cycles of polling have elapsed, the operation ends with `timeout_o`=1 and `ok_o`=0.
- R8: When `dev_err_i` is 1 together with an acknowledged read, polling ends with `ok_o`=0 and `timeout_o`=0. This holds during both polling and confirmation.
- R9: `done_o` is high for exactly one cycle and the block then returns to idle. A `start_i` during an operation has no effect on its address, data, kind or outcome.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Begin polling (after the final command write) |
| op_erase_i | input | 1 | 1 = erase, 0 = program |
| addr_i | input | ADDR_W | Address to poll |
| data_i | input | DATA_W | Byte being programmed |
| tmo_limit_i | input | TMO_W | Polling limit in clock cycles |
| bus_req_o | output | 1 | Read request |
| bus_addr_o | output | ADDR_W | Read address |
| bus_ack_i | input | 1 | Read data valid |
| bus_rdata_i | input | DATA_W | Read data |
| dev_err_i | input | 1 | Device error flag, sampled with `bus_ack_i` |
| done_o | output | 1 | One-cycle completion strobe |
| ok_o | output | 1 | Operation succeeded (valid with `done_o`) |
| timeout_o | output | 1 | Polling limit reached (valid with `done_o`) |
| result_o | output | DATA_W | Last byte read (valid with `done_o`) |

## Verification
The hardest case to reach is the one where bit 7 has already turned true but the confirming read disagrees. Through the ports this looks like an operation that finished. The bus model in the bench replays a scripted list of returned bytes, so a script can place a hit followed by a confirming byte whose low bits differ, or whose bit 7 has dropped back. The bench counts reads per operation to show that exactly one confirmation read follows the hit. It also injects a second start in the middle of polling and checks that the address on the bus never changes.

// File: rtl/fsp_pkg.sv
package fsp_pkg;
   typedef enum logic [1:0] {
      S_IDLE = 2'd0,
      S_POLL = 2'd1,
      S_CONF = 2'd2,
      S_DONE = 2'd3
   } fsp_state_t;
endpackage

// File: rtl/fsp_timer.sv
module fsp_timer #(
   parameter int W = 16
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         clear_i,
   input  logic         run_i,
   input  logic [W-1:0] limit_i,
   output logic         expired_o
);
   localparam logic [W-1:0] CNT_MAX = {W{1'b1}};

   logic [W-1:0] cnt;

   always_ff @(posedge clk) begin
      if (!rst_n)                        cnt <= '0;
      else if (clear_i)                  cnt <= '0;
      else if (run_i && cnt != CNT_MAX)  cnt <= cnt + 1'b1;
   end

   assign expired_o = (cnt >= limit_i);

   // R7
   no_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!clear_i && cnt != '0) |=> cnt != '0);
endmodule

// File: rtl/fsp_judge.sv
module fsp_judge #(
   parameter int DATA_W         = 8,
   parameter int POLL_BIT       = 7,
   parameter bit ERASE_ALL_ONES = 1'b0
) (
   input  logic              op_erase_i,
   input  logic [DATA_W-1:0] exp_i,
   input  logic [DATA_W-1:0] rdata_i,
   output logic              hit_o,
   output logic              final_ok_o
);
   logic erase_ok;

   generate
      if (ERASE_ALL_ONES) begin : g_erase_full
         assign erase_ok = &rdata_i;
      end else begin : g_erase_bit
         assign erase_ok = rdata_i[POLL_BIT];
      end
   endgenerate

   assign hit_o      = op_erase_i ? rdata_i[POLL_BIT]
                                  : (rdata_i[POLL_BIT] == exp_i[POLL_BIT]);
   assign final_ok_o = op_erase_i ? erase_ok : (rdata_i == exp_i);
endmodule

// File: rtl/flash_status_poller.sv
module flash_status_poller
   import fsp_pkg::*;
#(
   parameter int ADDR_W         = 20,
   parameter int DATA_W         = 8,
   parameter int POLL_BIT       = 7,
   parameter int TMO_W          = 16,
   parameter bit HAS_ERR_IN     = 1'b1,
   parameter bit ERASE_ALL_ONES = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start_i,
   input  logic              op_erase_i,
   input  logic [ADDR_W-1:0] addr_i,
   input  logic [DATA_W-1:0] data_i,
   input  logic [TMO_W-1:0]  tmo_limit_i,
   output logic              bus_req_o,
   output logic [ADDR_W-1:0] bus_addr_o,
   input  logic              bus_ack_i,
   input  logic [DATA_W-1:0] bus_rdata_i,
   input  logic              dev_err_i,
   output logic              done_o,
   output logic              ok_o,
   output logic              timeout_o,
   output logic [DATA_W-1:0] result_o
);
   localparam int RD_W = 2;

   initial begin
      param_chk: assert (POLL_BIT >= 0 && POLL_BIT < DATA_W && ADDR_W >= 1 && TMO_W >= 2)
         else $error("flash_status_poller: bad parameters");
   end

   fsp_state_t        st;
   logic [ADDR_W-1:0] addr_q;
   logic [DATA_W-1:0] data_q;
   logic              erase_q;
   logic [DATA_W-1:0] res_q;
   logic              ok_q, tmo_q;
   logic [RD_W-1:0]   rd_seen;
   logic              hit, final_ok, expired, err_s, take;

   generate
      if (HAS_ERR_IN) begin : g_err
         assign err_s = dev_err_i;
      end else begin : g_noerr
         logic unused_err;
         assign unused_err = dev_err_i;
         assign err_s      = 1'b0;
      end
   endgenerate

   assign take = (st == S_IDLE) && start_i;

   fsp_judge #(.DATA_W(DATA_W), .POLL_BIT(POLL_BIT), .ERASE_ALL_ONES(ERASE_ALL_ONES)) u_judge (
      .op_erase_i (erase_q),
      .exp_i      (data_q),
      .rdata_i    (bus_rdata_i),
      .hit_o      (hit),
      .final_ok_o (final_ok)
   );

   fsp_timer #(.W(TMO_W)) u_timer (
      .clk       (clk),
      .rst_n     (rst_n),
      .clear_i   (take),
      .run_i     (st == S_POLL),
      .limit_i   (tmo_limit_i),
      .expired_o (expired)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st      <= S_IDLE;
         addr_q  <= '0;
         data_q  <= '0;
         erase_q <= 1'b0;
         res_q   <= '0;
         ok_q    <= 1'b0;
         tmo_q   <= 1'b0;
      end else begin
         unique case (st)
            S_IDLE: if (start_i) begin
               st      <= S_POLL;
               addr_q  <= addr_i;
               data_q  <= data_i;
               erase_q <= op_erase_i;
               ok_q    <= 1'b0;
               tmo_q   <= 1'b0;
            end
            S_POLL: begin
               if (bus_ack_i && err_s) begin
                  res_q <= bus_rdata_i;
                  st    <= S_DONE;
               end else if (bus_ack_i && hit) begin
                  st <= S_CONF;
               end else if (expired) begin
                  if (bus_ack_i) res_q <= bus_rdata_i;
                  tmo_q <= 1'b1;
                  st    <= S_DONE;
               end
            end
            S_CONF: if (bus_ack_i) begin
               res_q <= bus_rdata_i;
               ok_q  <= final_ok && !err_s;
               st    <= S_DONE;
            end
            S_DONE: st <= S_IDLE;
            default: st <= S_IDLE;
         endcase
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n)                       rd_seen <= '0;
      else if (take)                    rd_seen <= '0;
      else if (bus_req_o && bus_ack_i && rd_seen != {RD_W{1'b1}})
                                        rd_seen <= rd_seen + 1'b1;
   end

   assign bus_req_o  = (st == S_POLL) || (st == S_CONF);
   assign bus_addr_o = addr_q;
   assign done_o     = (st == S_DONE);
   assign ok_o       = ok_q;
   assign timeout_o  = tmo_q;
   assign result_o   = res_q;

   // R9
   done_once_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |=> (!done_o && !bus_req_o));
   // R2
   start_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
      take |-> (!bus_req_o ##1 (bus_req_o && bus_addr_o == $past(addr_i))));
   // R5
   confirm_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (done_o && ok_o) |-> (rd_seen >= 2'd2));
   // R7
   tmo_fail_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (done_o && timeout_o) |-> !ok_o);
   // R9
   busy_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (st == S_POLL && start_i) |=> ($stable(addr_q) && $stable(data_q) && $stable(erase_q)));
endmodule

// File: tb/flash_status_poller_tb.sv
`timescale 1ns/1ps
module flash_status_poller_tb;
   typedef struct {
      bit          ok;
      bit          tmo;
      logic [7:0]  res;
      int          reads;
   } exp_t;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start_i = 1'b0;
   logic        op_erase_i = 1'b0;
   logic [19:0] addr_i = '0;
   logic [7:0]  data_i = '0;
   logic [15:0] tmo_limit_i = 16'd1000;
   logic        bus_req_o;
   logic [19:0] bus_addr_o;
   logic        bus_ack_i = 1'b0;
   logic [7:0]  bus_rdata_i = '0;
   logic        dev_err_i = 1'b0;
   logic        done_o, ok_o, timeout_o;
   logic [7:0]  result_o;

   int          n_chk = 0;
   int          n_fail = 0;
   int          n_done = 0;
   int          reads = 0;
   bit          addr_bad = 1'b0;
   bit          prev_done = 1'b0;
   logic [19:0] cur_addr = '0;
   logic [7:0]  fill = '0;
   logic [8:0]  resp_q[$];
   exp_t        exp_q[$];

   always #4 clk = ~clk;

   flash_status_poller u_dut (
      .clk(clk), .rst_n(rst_n), .start_i(start_i), .op_erase_i(op_erase_i),
      .addr_i(addr_i), .data_i(data_i), .tmo_limit_i(tmo_limit_i),
      .bus_req_o(bus_req_o), .bus_addr_o(bus_addr_o), .bus_ack_i(bus_ack_i),
      .bus_rdata_i(bus_rdata_i), .dev_err_i(dev_err_i), .done_o(done_o),
      .ok_o(ok_o), .timeout_o(timeout_o), .result_o(result_o)
   );

   task automatic check(input bit cond, input string req, input int act, input int exp);
      n_chk++;
      if (!cond) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   // bus model: scripted read responses, one-cycle ack
   always @(negedge clk) begin
      logic [8:0] r;
      if (!rst_n) begin
         bus_ack_i = 1'b0;
         dev_err_i = 1'b0;
      end else if (bus_ack_i) begin
         bus_ack_i = 1'b0;
         dev_err_i = 1'b0;
      end else if (bus_req_o) begin
         if (resp_q.size() > 0) r = resp_q.pop_front();
         else                   r = {1'b0, fill};
         bus_ack_i   = 1'b1;
         bus_rdata_i = r[7:0];
         dev_err_i   = r[8];
         reads++;
         if (bus_addr_o != cur_addr) addr_bad = 1'b1;
      end
   end

   // monitor: pops the expected outcome on each done
   always @(negedge clk) begin
      exp_t e;
      if (rst_n) begin
         if (prev_done) check(!done_o, "R9 done one cycle", done_o, 0);
         prev_done = done_o;
         if (done_o) begin
            e = exp_q.pop_front();
            check(ok_o == e.ok, "R6/R8 ok", ok_o, e.ok);
            check(timeout_o == e.tmo, "R7 timeout", timeout_o, e.tmo);
            if (!e.tmo) check(result_o == e.res, "R5 result", result_o, e.res);
            if (e.reads >= 0) check(reads == e.reads, "R5 read count", reads, e.reads);
            check(!addr_bad, "R2 bus address", addr_bad, 0);
            n_done++;
         end
      end
   end

   task automatic run_op(input bit er, input logic [19:0] a, input logic [7:0] d,
                         input logic [15:0] lim, input logic [7:0] fl,
                         input bit eok, input bit etmo, input logic [7:0] eres,
                         input int erd, input bit intrude);
      exp_t e;
      int   target;
      e.ok = eok; e.tmo = etmo; e.res = eres; e.reads = erd;
      exp_q.push_back(e);
      target      = n_done + 1;
      reads       = 0;
      addr_bad    = 1'b0;
      cur_addr    = a;
      fill        = fl;
      tmo_limit_i = lim;
      @(negedge clk);
      op_erase_i = er; addr_i = a; data_i = d; start_i = 1'b1;
      check(!bus_req_o, "R2 no request in start cycle", bus_req_o, 0);
      @(negedge clk);
      start_i = 1'b0;
      check(bus_req_o, "R2 request after start", bus_req_o, 1);
      if (intrude) begin
         repeat (2) @(negedge clk);
         op_erase_i = ~er; addr_i = a ^ 20'h00FF; data_i = ~d; start_i = 1'b1;
         @(negedge clk);
         start_i = 1'b0;
      end
      wait (n_done == target);
      @(negedge clk);
      resp_q.delete();
   endtask

   initial begin
      repeat (3) @(negedge clk);
      // R1
      check(!done_o && !bus_req_o && !ok_o && !timeout_o, "R1 reset state",
            {done_o, bus_req_o, ok_o, timeout_o}, 0);
      rst_n = 1'b1;
      @(negedge clk);

      // R3: program A5, hit on third read, confirm matches
      resp_q = '{9'h025, 9'h025, 9'h0A5, 9'h0A5};
      run_op(0, 20'h00123, 8'hA5, 16'd1000, 8'h25, 1, 0, 8'hA5, 4, 0);
      // R3: program with bit 7 = 0
      resp_q = '{9'h0BC, 9'h03C, 9'h03C};
      run_op(0, 20'h0A000, 8'h3C, 16'd1000, 8'hBC, 1, 0, 8'h3C, 3, 0);
      // R6: bit 7 true but low bits differ on confirm
      resp_q = '{9'h001, 9'h080, 9'h080};
      run_op(0, 20'h00777, 8'h81, 16'd1000, 8'h01, 0, 0, 8'h80, 3, 0);
      // R4: erase
      resp_q = '{9'h000, 9'h07F, 9'h080, 9'h0FF};
      run_op(1, 20'h40000, 8'h00, 16'd1000, 8'h00, 1, 0, 8'hFF, 4, 0);
      // R6: erase confirm drops back to 0
      resp_q = '{9'h080, 9'h000};
      run_op(1, 20'h50000, 8'h00, 16'd1000, 8'h00, 0, 0, 8'h00, 2, 0);
      // R8: error while polling
      resp_q = '{9'h000, 9'h100};
      run_op(0, 20'h00010, 8'h80, 16'd1000, 8'h00, 0, 0, 8'h00, 2, 0);
      // R8: error on confirm read
      resp_q = '{9'h080, 9'h180};
      run_op(0, 20'h00020, 8'h80, 16'd1000, 8'h00, 0, 0, 8'h80, 2, 0);
      // R7: never completes
      run_op(1, 20'h60000, 8'h00, 16'd12, 8'h00, 0, 1, 8'h00, -1, 0);
      // R9: start during polling ignored
      resp_q = '{9'h0D5, 9'h0D5, 9'h0D5, 9'h055, 9'h055};
      run_op(0, 20'h00040, 8'h55, 16'd1000, 8'hD5, 1, 0, 8'h55, 5, 1);
      // R9: idle afterwards
      repeat (3) @(negedge clk);
      check(!bus_req_o && !done_o, "R9 idle after done", bus_req_o, 0);

      $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      n_chk++;
      n_fail++;
      $display("FAIL watchdog actual=%0d expected=%0d", n_done, 9);
      $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
   end
endmodule